// File: doc/BRIEF.md
# Three-Channel Prioritized DMA Controller

This block moves data between addresses of a single-port memory bus with no processor involvement. It has three independent channels. Each channel holds a starting source address, a starting destination address, a unit count and a control word. The control word picks the transfer mode, whether each address stays fixed or steps forward, the unit size on each side, and whether the trigger input is edge or level sensitive. Every unit costs exactly one read cycle followed by one write cycle on the bus.

A request line per channel starts the work. Single mode moves one unit per trigger. Block mode moves the whole count back to back. Burst-block mode also moves the whole count, but it releases the bus for one idle cycle after every four units, and the arbiter may then hand the bus to another channel. When a channel has moved its last unit it pulses its completion line. It then either disarms itself or, when repeat is selected, reloads its starting values. A single input chooses between fixed priority and rotating priority.

Top module: `mdma_top`

## Requirements
- R1: Every unit is moved as one cycle with `mem_rd` high, followed in the next cycle by one cycle with `mem_wr` high. Both are never high together, and every read is followed by a write.
- R2: An incrementing source or destination address steps by 1 for byte units and by 2 for word units. A fixed address keeps its starting value. The addressing bits are control bit 4 (source increments) and bit 5 (destination increments).
- R3: Control bit 6 selects byte source units and bit 7 selects byte destination units. A byte read feeds a word write as the byte zero-extended. A word read feeds a byte write as its low byte. The bus carries a byte access on `mem_wdata[7:0]`/`mem_rdata[7:0]` with `mem_byte` high, and a word access little-endian at address and address+1.
- R4: Mode field bits [3:2] = 0 selects single mode. Each trigger then moves exactly one unit.
- R5: Mode value 1 selects block mode. One trigger then moves the whole count, and successive reads are exactly two cycles apart.
- R6: Mode value 2 selects burst-block mode. After every fourth unit of a block there is exactly one idle bus cycle, so the gap between that read and the next is three cycles.
- R7: Control bit 8 clear selects an edge trigger: holding the request high yields only one trigger. Bit 8 set selects a level trigger: the channel keeps requesting while the line stays high.
- R8: A channel whose count is zero never starts a transfer, even when it is enabled and triggered.
- R9: After the final write of a block, exactly one channel's bit of `done_irq` is high for one cycle. Without repeat (control bit 1), the enable (bit 0) is cleared and further triggers are ignored. With repeat, the starting values are reloaded and the next trigger runs the block again.
- R10: With `rotate_pri` low, the lowest-numbered requesting channel wins the bus.
- R11: With `rotate_pri` high, the channel that moved the last unit becomes the lowest priority, so that continuously requesting channels take turns 0, 1, 2.
- R12: After reset there is no bus activity and no completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 2 | Channel addressed by the write |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| cfg_wdata | input | 16 | Configuration write data |
| trig_req | input | 3 | Per-channel trigger request lines |
| rotate_pri | input | 1 | 0 fixed priority, 1 rotating priority |
| mem_addr | output | 16 | Bus byte address |
| mem_rd | output | 1 | Read cycle |
| mem_wr | output | 1 | Write cycle |
| mem_byte | output | 1 | Access is one byte |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid in the read cycle |
| done_irq | output | 3 | One-cycle block completion pulses |

## Verification
The bound checker watches the bus protocol on every cycle: reads and writes never overlap, each read is followed by a write, and each write is preceded by a read. It also checks that completion pulses are one-hot, last a single cycle and come directly after a write. Only the bench scenarios can show the data and ordering effects. These are the address stepping and unit conversion, checked against a bench model of memory; the read spacing of block and burst modes; the edge and level trigger counts; the zero-count and disarm behaviour; and the grant order under both priority schemes.

// File: rtl/mdma_pkg.sv
package mdma_pkg;
  localparam int CTRL_W   = 9;
  localparam int CB_EN    = 0;
  localparam int CB_RPT   = 1;
  localparam int CB_MODE  = 2;
  localparam int CB_SINC  = 4;
  localparam int CB_DINC  = 5;
  localparam int CB_SBYTE = 6;
  localparam int CB_DBYTE = 7;
  localparam int CB_LEVEL = 8;

  localparam logic [1:0] MODE_SINGLE = 2'd0;
  localparam logic [1:0] MODE_BLOCK  = 2'd1;
  localparam logic [1:0] MODE_BURST  = 2'd2;

  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_DST  = 2'd1;
  localparam logic [1:0] SEL_SIZE = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} eng_state_e;
endpackage

// File: rtl/mdma_chan.sv
module mdma_chan
  import mdma_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_we,
  input  logic [1:0]   cfg_sel,
  input  logic [W-1:0] cfg_wdata,
  input  logic         trig_i,
  input  logic         step_i,
  output logic         req_o,
  output logic         last_o,
  output logic [W-1:0] src_o,
  output logic [W-1:0] dst_o,
  output logic         sbyte_o,
  output logic         dbyte_o,
  output logic [1:0]   mode_o,
  output logic         done_o
);
  logic [W-1:0]      src_base, src_base_n, dst_base, dst_base_n;
  logic [W-1:0]      src_cur, src_cur_n, dst_cur, dst_cur_n;
  logic [W-1:0]      size_r, size_n, cnt, cnt_n;
  logic [CTRL_W-1:0] ctrl_r, ctrl_n;
  logic              pend, pend_n, active, active_n, trig_q, done_r, done_n;
  logic              rise, fire;
  logic [W-1:0]      s_unit, d_unit;

  assign rise    = trig_i & ~trig_q;
  assign fire    = ctrl_r[CB_LEVEL] ? trig_i : pend;
  assign req_o   = ctrl_r[CB_EN] & (cnt != '0) & (active | fire);
  assign last_o  = (cnt == W'(1));
  assign src_o   = src_cur;
  assign dst_o   = dst_cur;
  assign sbyte_o = ctrl_r[CB_SBYTE];
  assign dbyte_o = ctrl_r[CB_DBYTE];
  assign mode_o  = ctrl_r[CB_MODE+1:CB_MODE];
  assign done_o  = done_r;
  assign s_unit  = ctrl_r[CB_SINC] ? (ctrl_r[CB_SBYTE] ? W'(1) : W'(2)) : '0;
  assign d_unit  = ctrl_r[CB_DINC] ? (ctrl_r[CB_DBYTE] ? W'(1) : W'(2)) : '0;

  always_comb begin
    src_base_n = src_base;
    dst_base_n = dst_base;
    src_cur_n  = src_cur;
    dst_cur_n  = dst_cur;
    size_n     = size_r;
    cnt_n      = cnt;
    ctrl_n     = ctrl_r;
    pend_n     = pend | rise;
    active_n   = active;
    done_n     = 1'b0;
    if (step_i) begin
      pend_n    = rise;
      src_cur_n = src_cur + s_unit;
      dst_cur_n = dst_cur + d_unit;
      cnt_n     = cnt - W'(1);
      active_n  = (mode_o != MODE_SINGLE);
      if (last_o) begin
        done_n   = 1'b1;
        active_n = 1'b0;
        if (ctrl_r[CB_RPT]) begin
          cnt_n     = size_r;
          src_cur_n = src_base;
          dst_cur_n = dst_base;
        end else begin
          ctrl_n[CB_EN] = 1'b0;
        end
      end
    end
    if (cfg_we) begin
      unique case (cfg_sel)
        SEL_SRC:  begin src_base_n = cfg_wdata; src_cur_n = cfg_wdata; end
        SEL_DST:  begin dst_base_n = cfg_wdata; dst_cur_n = cfg_wdata; end
        SEL_SIZE: begin size_n = cfg_wdata; cnt_n = cfg_wdata; end
        default: begin
          ctrl_n   = cfg_wdata[CTRL_W-1:0];
          pend_n   = 1'b0;
          active_n = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_base <= '0;
      dst_base <= '0;
      src_cur  <= '0;
      dst_cur  <= '0;
      size_r   <= '0;
      cnt      <= '0;
      ctrl_r   <= '0;
      pend     <= 1'b0;
      active   <= 1'b0;
      trig_q   <= 1'b0;
      done_r   <= 1'b0;
    end else begin
      src_base <= src_base_n;
      dst_base <= dst_base_n;
      src_cur  <= src_cur_n;
      dst_cur  <= dst_cur_n;
      size_r   <= size_n;
      cnt      <= cnt_n;
      ctrl_r   <= ctrl_n;
      pend     <= pend_n;
      active   <= active_n;
      trig_q   <= trig_i;
      done_r   <= done_n;
    end
  end
endmodule

// File: rtl/mdma_arb.sv
module mdma_arb #(
  parameter int NCH = 3,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] req_i,
  input  logic           rotate_i,
  input  logic [IW-1:0]  last_i,
  output logic           valid_o,
  output logic [IW-1:0]  gnt_o
);
  int c;

  always_comb begin
    valid_o = |req_i;
    gnt_o   = '0;
    c       = 0;
    for (int off = NCH - 1; off >= 0; off--) begin
      c = rotate_i ? ((int'(last_i) + 1 + off) % NCH) : off;
      if (req_i[c]) gnt_o = IW'(c);
    end
  end
endmodule

// File: rtl/mdma_top.sv
module mdma_top
  import mdma_pkg::*;
#(
  parameter int NCH       = 3,
  parameter int W         = 16,
  parameter int BURST_LEN = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int BW = $clog2(BURST_LEN + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [IW-1:0]  cfg_ch,
  input  logic [1:0]     cfg_sel,
  input  logic [W-1:0]   cfg_wdata,
  input  logic [NCH-1:0] trig_req,
  input  logic           rotate_pri,
  output logic [W-1:0]   mem_addr,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           mem_byte,
  output logic [W-1:0]   mem_wdata,
  input  logic [W-1:0]   mem_rdata,
  output logic [NCH-1:0] done_irq
);
  eng_state_e     state, state_n;
  logic [IW-1:0]  gnt, gnt_n, last_gnt, last_gnt_n, arb_idx;
  logic [BW-1:0]  beat, beat_n;
  logic [W-1:0]   data_q, data_n;
  logic           arb_valid;
  logic [NCH-1:0] req, last, sbyte, dbyte, step;
  logic [W-1:0]   src_a [NCH];
  logic [W-1:0]   dst_a [NCH];
  logic [1:0]     mode_a [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    mdma_chan #(.W(W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we && (cfg_ch == IW'(g))),
      .cfg_sel  (cfg_sel),
      .cfg_wdata(cfg_wdata),
      .trig_i   (trig_req[g]),
      .step_i   (step[g]),
      .req_o    (req[g]),
      .last_o   (last[g]),
      .src_o    (src_a[g]),
      .dst_o    (dst_a[g]),
      .sbyte_o  (sbyte[g]),
      .dbyte_o  (dbyte[g]),
      .mode_o   (mode_a[g]),
      .done_o   (done_irq[g])
    );
  end

  mdma_arb #(.NCH(NCH)) u_arb (
    .req_i   (req),
    .rotate_i(rotate_pri),
    .last_i  (last_gnt),
    .valid_o (arb_valid),
    .gnt_o   (arb_idx)
  );

  always_comb begin
    state_n    = state;
    gnt_n      = gnt;
    last_gnt_n = last_gnt;
    beat_n     = beat;
    data_n     = data_q;
    step       = '0;
    unique case (state)
      ST_IDLE: begin
        beat_n = '0;
        if (arb_valid) begin
          gnt_n   = arb_idx;
          state_n = ST_RD;
        end
      end
      ST_RD: begin
        data_n  = sbyte[gnt] ? {{(W-8){1'b0}}, mem_rdata[7:0]} : mem_rdata;
        state_n = ST_WR;
      end
      ST_WR: begin
        step[gnt]  = 1'b1;
        last_gnt_n = gnt;
        beat_n     = beat + BW'(1);
        state_n    = ST_IDLE;
        if ((mode_a[gnt] != MODE_SINGLE) && !last[gnt]) begin
          if ((mode_a[gnt] == MODE_BURST) && (beat_n == BW'(BURST_LEN))) begin
            beat_n = '0;
          end else begin
            state_n = ST_RD;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      gnt      <= '0;
      last_gnt <= IW'(NCH - 1);
      beat     <= '0;
      data_q   <= '0;
    end else begin
      state    <= state_n;
      gnt      <= gnt_n;
      last_gnt <= last_gnt_n;
      beat     <= beat_n;
      data_q   <= data_n;
    end
  end

  assign mem_rd    = (state == ST_RD);
  assign mem_wr    = (state == ST_WR);
  assign mem_addr  = mem_rd ? src_a[gnt] : (mem_wr ? dst_a[gnt] : '0);
  assign mem_byte  = mem_rd ? sbyte[gnt] : (mem_wr & dbyte[gnt]);
  assign mem_wdata = dbyte[gnt] ? {{(W-8){1'b0}}, data_q[7:0]} : data_q;
endmodule

// File: rtl/mdma_chk.sv
module mdma_chk #(
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mem_rd,
  input logic           mem_wr,
  input logic [NCH-1:0] done_irq
);
  p_rd_wr_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  p_rd_then_wr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> mem_wr);
  p_wr_has_rd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd));
  p_done_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_irq));
  p_done_after_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_irq) |-> $past(mem_wr));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_irq) |=> (done_irq == '0));
endmodule

bind mdma_top mdma_chk #(.NCH(NCH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mem_rd  (mem_rd),
  .mem_wr  (mem_wr),
  .done_irq(done_irq)
);

// File: tb/mdma_top_tb_top.sv
module mdma_top_tb_top;
  localparam int NCH = 3;
  localparam int W   = 16;
  localparam logic [15:0] EN = 16'h001, RPT = 16'h002, BLK = 16'h004, BST = 16'h008;
  localparam logic [15:0] SINC = 16'h010, DINC = 16'h020, SB = 16'h040, DB = 16'h080, LVL = 16'h100;
  // flags {sinc,dinc,sbyte,dbyte}, src, dst, count
  localparam logic [27:0] VEC [6] = '{
    {4'b1111, 8'h10, 8'h80, 8'd5},
    {4'b1100, 8'h20, 8'h90, 8'd4},
    {4'b1110, 8'h30, 8'hA0, 8'd4},
    {4'b1101, 8'h40, 8'hB0, 8'd4},
    {4'b0111, 8'h50, 8'hC0, 8'd3},
    {4'b1011, 8'h60, 8'hD0, 8'd3}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we;
  logic [1:0] cfg_ch, cfg_sel;
  logic [W-1:0] cfg_wdata, mem_addr, mem_wdata, mem_rdata;
  logic [NCH-1:0] trig_req, done_irq;
  logic rotate_pri, mem_rd, mem_wr, mem_byte;

  logic [7:0] mem [256];
  logic [7:0] exp_m [256];
  logic fill_req;
  logic [7:0] fill_seed;
  logic log_clr;
  int cyc, nrd, nwr, ndone;
  int rd_t [64];
  logic [15:0] rd_a [64];
  int checks, failures;
  bit wd;
  logic [27:0] e;
  logic [15:0] ctl, val;
  int s, d, bad;
  int ord [6];

  always #5 clk = ~clk;

  mdma_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .trig_req(trig_req), .rotate_pri(rotate_pri),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_byte(mem_byte),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done_irq(done_irq)
  );

  always @(posedge clk) begin
    if (fill_req) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7) ^ fill_seed;
    end else if (mem_wr) begin
      mem[mem_addr[7:0]] <= mem_wdata[7:0];
      if (!mem_byte) mem[mem_addr[7:0] + 8'd1] <= mem_wdata[15:8];
    end
  end
  assign mem_rdata = mem_byte ? {8'h00, mem[mem_addr[7:0]]}
                              : {mem[mem_addr[7:0] + 8'd1], mem[mem_addr[7:0]]};

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (log_clr) begin
      nrd <= 0; nwr <= 0; ndone <= 0;
    end else begin
      if (mem_rd) begin
        if (nrd < 64) begin rd_t[nrd] <= cyc; rd_a[nrd] <= mem_addr; end
        nrd <= nrd + 1;
      end
      if (mem_wr) nwr <= nwr + 1;
      if (|done_irq) ndone <= ndone + 1;
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic wr_cfg(int ch, int sel, logic [15:0] dv);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = 2'(sel); cfg_wdata = dv;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic setup(int ch, logic [15:0] sa, logic [15:0] da, logic [15:0] sz, logic [15:0] cw);
    wr_cfg(ch, 3, 16'h0);
    wr_cfg(ch, 0, sa);
    wr_cfg(ch, 1, da);
    wr_cfg(ch, 2, sz);
    wr_cfg(ch, 3, cw);
  endtask

  task automatic clear_log();
    log_clr = 1'b1; tick(1); log_clr = 1'b0;
  endtask

  task automatic pulse(int ch);
    trig_req[ch] = 1'b1; tick(1); trig_req[ch] = 1'b0;
  endtask

  task automatic fill(logic [7:0] seed);
    fill_seed = seed; fill_req = 1'b1; tick(1); fill_req = 1'b0; tick(1);
  endtask

  task automatic run_all();
    // R12: reset state
    @(negedge clk);
    chk(mem_rd == 1'b0, "R12 mem_rd after reset", int'(mem_rd), 0);
    chk(mem_wr == 1'b0, "R12 mem_wr after reset", int'(mem_wr), 0);
    chk(done_irq == '0, "R12 done_irq after reset", int'(done_irq), 0);
    tick(1);

    // Table walk: R2, R3 addressing and unit conversion; R1 and R5 in block mode
    for (int v = 0; v < 6; v++) begin
      e = VEC[v];
      fill(8'(v * 16 + 3));
      for (int i = 0; i < 256; i++) exp_m[i] = mem[i];
      for (int k = 0; k < int'(e[7:0]); k++) begin
        s = int'(e[23:16]) + (e[27] ? k * (e[25] ? 1 : 2) : 0);
        d = int'(e[15:8]) + (e[26] ? k * (e[24] ? 1 : 2) : 0);
        val = e[25] ? {8'h00, mem[s]} : {mem[s + 1], mem[s]};
        exp_m[d] = val[7:0];
        if (!e[24]) exp_m[d + 1] = val[15:8];
      end
      ctl = EN | BLK | (e[27] ? SINC : 16'h0) | (e[26] ? DINC : 16'h0)
          | (e[25] ? SB : 16'h0) | (e[24] ? DB : 16'h0);
      setup(0, {8'h00, e[23:16]}, {8'h00, e[15:8]}, {8'h00, e[7:0]}, ctl);
      clear_log();
      pulse(0);
      tick(40);
      bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== exp_m[i]) bad++;
      chk(bad == 0, "R2 R3 memory image mismatching bytes", bad, 0);
      chk(nwr == nrd && nrd == int'(e[7:0]), "R1 R5 read/write count", nrd, int'(e[7:0]));
      bad = 0;
      for (int k = 1; k < int'(e[7:0]); k++) if (rd_t[k] - rd_t[k-1] != 2) bad++;
      chk(bad == 0, "R5 non-two-cycle read spacing count", bad, 0);
      chk(ndone == 1, "R9 done pulses per block", ndone, 1);
    end

    // R6: burst-block spacing
    fill(8'h5A);
    setup(0, 16'h0010, 16'h0080, 16'd8, EN | BST | SINC | DINC | SB | DB);
    clear_log();
    pulse(0);
    tick(40);
    chk(nrd == 8, "R6 burst read count", nrd, 8);
    chk(rd_t[1] - rd_t[0] == 2, "R6 spacing inside burst", rd_t[1] - rd_t[0], 2);
    chk(rd_t[4] - rd_t[3] == 3, "R6 spacing across idle cycle", rd_t[4] - rd_t[3], 3);
    chk(rd_t[5] - rd_t[4] == 2, "R6 spacing after idle", rd_t[5] - rd_t[4], 2);

    // R7 edge trigger held high, R4 single mode one unit per trigger
    setup(0, 16'h0010, 16'h0080, 16'd3, EN | SINC | DINC | SB | DB);
    clear_log();
    trig_req[0] = 1'b1; tick(12); trig_req[0] = 1'b0; tick(2);
    chk(nwr == 1, "R7 edge trigger held high moves one unit", nwr, 1);
    pulse(0); tick(10);
    chk(nwr == 2, "R4 second trigger moves one more unit", nwr, 2);
    chk(ndone == 0, "R4 no done before count exhausted", ndone, 0);

    // R7 level trigger, then R9 disarm
    setup(1, 16'h0010, 16'h0090, 16'd3, EN | LVL | SINC | DINC | SB | DB);
    clear_log();
    trig_req[1] = 1'b1; tick(30);
    chk(nwr == 3, "R7 level trigger moves all units", nwr, 3);
    chk(ndone == 1, "R9 done after last single unit", ndone, 1);
    clear_log();
    tick(20);
    chk(nrd == 0, "R9 disarmed channel ignores held request", nrd, 0);
    trig_req[1] = 1'b0; tick(1);

    // R8: count zero
    setup(2, 16'h0010, 16'h00A0, 16'd0, EN | BLK | SINC | DINC);
    clear_log();
    pulse(2); tick(20);
    chk(nrd == 0, "R8 zero count starts no transfer", nrd, 0);

    // R9: repeat
    setup(2, 16'h0010, 16'h00A0, 16'd2, EN | RPT | BLK | SINC | DINC | SB | DB);
    clear_log();
    pulse(2); tick(20);
    chk(nwr == 2 && ndone == 1, "R9 repeat first block writes", nwr, 2);
    pulse(2); tick(20);
    chk(nwr == 4, "R9 repeat reruns block", nwr, 4);
    chk(ndone == 2, "R9 repeat second done", ndone, 2);

    // R10: fixed priority
    rotate_pri = 1'b0;
    setup(0, 16'h0000, 16'h0020, 16'd2, EN | LVL | SINC | DINC | SB | DB);
    setup(1, 16'h0040, 16'h0060, 16'd2, EN | LVL | SINC | DINC | SB | DB);
    setup(2, 16'h0080, 16'h00A0, 16'd2, EN | LVL | SINC | DINC | SB | DB);
    clear_log();
    trig_req = 3'b111; tick(30); trig_req = 3'b000; tick(1);
    ord = '{0, 0, 1, 1, 2, 2};
    chk(nrd == 6, "R10 total reads", nrd, 6);
    for (int k = 0; k < 6; k++)
      chk(int'(rd_a[k][7:6]) == ord[k], "R10 fixed grant order", int'(rd_a[k][7:6]), ord[k]);

    // R11: rotating priority
    rotate_pri = 1'b1;
    setup(0, 16'h0000, 16'h0020, 16'd2, EN | LVL | SINC | DINC | SB | DB);
    setup(1, 16'h0040, 16'h0060, 16'd2, EN | LVL | SINC | DINC | SB | DB);
    setup(2, 16'h0080, 16'h00A0, 16'd2, EN | LVL | SINC | DINC | SB | DB);
    clear_log();
    trig_req = 3'b111; tick(30); trig_req = 3'b000; tick(1);
    ord = '{0, 1, 2, 0, 1, 2};
    chk(nrd == 6, "R11 total reads", nrd, 6);
    for (int k = 0; k < 6; k++)
      chk(int'(rd_a[k][7:6]) == ord[k], "R11 rotating grant order", int'(rd_a[k][7:6]), ord[k]);
  endtask

  initial begin
    checks = 0; failures = 0; wd = 1'b0;
    cyc = 0; nrd = 0; nwr = 0; ndone = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_ch = '0; cfg_sel = '0; cfg_wdata = '0;
    trig_req = '0; rotate_pri = 1'b0; fill_req = 1'b0; fill_seed = '0; log_clr = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    fork
      run_all();
      begin repeat (100000) @(posedge clk); wd = 1'b1; end
    join_any
    disable fork;
    if (wd) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule